// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns each access of a 32-bit bus master into at most one active-low external chip select. It has eight channels. Each channel holds a base value, a mask value and a control value, all written through a small register port. On every access the upper half of the address (bits 31 to 16) is compared with each channel's base. Any bit that the channel's mask marks as don't-care is skipped, so the decode granularity is 64 KB. A channel with n mask bits set covers 2^(n+16) bytes.

Channel 0 has a special role after reset. Until software validates it, channel 0 selects on every access, whatever the address, and all other channels stay quiet. This lets a boot ROM be fetched before any setup has run. Once channel 0 is validated, it decodes like the others. When several valid channels match, the lowest-numbered one wins. A write that lands in a write-protected region drives no select and raises an access-error flag instead. The decode path is purely combinational. Only the configuration registers are clocked.

Top module: `csdec_top`

## Requirements
- R1: After reset every base and mask register reads zero, so every valid and write-protect bit is clear. Channel 0's control register reads 0x0000_3D80 and the other control registers read zero. Selector codes are 0 = base, 1 = mask, 2 = control, and 3 reads zero.
- R2: While channel 0's valid bit (mask register bit 0) is clear, every access asserts cs_n[0] regardless of address. No other select asserts in that state, even for valid channels whose base matches.
- R3: Only address bits 31..16 take part in the compare. Each set bit in mask register bits 31..16 makes the matching bit a don't-care. Every cleared bit requires equality with the base register bits 31..16.
- R4: A channel covers 2^(n+16) bytes for n set mask bits. As an example, base 0x0000 with mask 0x01FF spans 0x0000_0000 to 0x01FF_FFFF. A second channel with base 0x0200 and mask 0x00FF then spans 0x0200_0000 to 0x02FF_FFFF.
- R5: Channels 1 to 7 never assert while their own valid bit is clear.
- R6: When several valid channels match, only the lowest-numbered one asserts.
- R7: If the winning channel has its write-protect bit (mask register bit 1) set, a write asserts no select and raises acc_err for that access. A read to the same region asserts the select normally, with acc_err low.
- R8: An access that matches no valid channel asserts no select and leaves acc_err low.
- R9: While bus_valid is low, all selects are high and acc_err is low.
- R10: A register write is stored on the clock edge where cfg_we is high. It reads back through cfg_rdata and governs decode from the next cycle on. Readback layout is: base in bits 31..16; mask in bits 31..16 with write-protect in bit 1 and valid in bit 0; control in bits 15..0. All other bits read zero.
- R11: At most one chip select is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 3 | Channel index for register write and readback |
| cfg_sel | input | 2 | Register selector: 0 base, 1 mask, 2 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| bus_valid | input | 1 | An access is present this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr_hi | input | 16 | Address bits 31..16 of the access |
| cs_n | output | 8 | Active-low chip selects, one per channel |
| acc_err | output | 1 | Write to a write-protected region |

## Verification
A corrupted base, mask or flag bit in a channel shows up at cs_n or acc_err on the first access whose address falls in the affected range. It also shows up at once on cfg_rdata when that register is read back. A lost valid bit on channel 0 makes every access select cs_n[0], so the fault appears in the very first cycle of decoding. The bench compares both decode outputs against a behavioural model in every cycle, across directed and random address patterns. It also reads back registers after every group of writes.

// File: rtl/csdec_pkg.sv
// Package: shared types for the chip-select decoder.
// Assumes compare width of 16 upper address bits and a 32-bit register port.
package csdec_pkg;
    localparam int REG_W  = 32;
    localparam int CMP_W  = 16;
    localparam int CTRL_W = 16;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CMP_W-1:0]  base;
        logic [CMP_W-1:0]  mask;
        logic              wp;
        logic              vld;
        logic [CTRL_W-1:0] ctrl;
    } ch_cfg_t;
endpackage

// File: rtl/csdec_regs.sv
// Module: per-channel configuration storage with combinational readback.
// Assumes one write per cycle; channel 0 control has its own reset value.
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int                NUM_CH    = 8,
    parameter int                CH_W      = 3,
    parameter logic [CTRL_W-1:0] CTRL_RST0 = 16'h3D80,
    parameter logic [CTRL_W-1:0] CTRL_RSTN = 16'h0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [CH_W-1:0]            ch,
    input  logic [1:0]                 sel,
    input  logic [REG_W-1:0]           wdata,
    output logic [REG_W-1:0]           rdata,
    output ch_cfg_t [NUM_CH-1:0]       cfg_o
);
    ch_cfg_t [NUM_CH-1:0] cfg_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [CTRL_W-1:0] RST_CTRL = (i == 0) ? CTRL_RST0 : CTRL_RSTN;
        logic hit_w;
        assign hit_w = we && (ch == CH_W'(i));

        // Store base/mask/control for this channel on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i].base <= '0;
                cfg_q[i].mask <= '0;
                cfg_q[i].wp   <= 1'b0;
                cfg_q[i].vld  <= 1'b0;
                cfg_q[i].ctrl <= RST_CTRL;
            end else if (hit_w) begin
                case (cfg_sel_e'(sel))
                    SEL_BASE: cfg_q[i].base <= wdata[REG_W-1 -: CMP_W];
                    SEL_MASK: begin
                        cfg_q[i].mask <= wdata[REG_W-1 -: CMP_W];
                        cfg_q[i].wp   <= wdata[1];
                        cfg_q[i].vld  <= wdata[0];
                    end
                    SEL_CTRL: cfg_q[i].ctrl <= wdata[CTRL_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    ch_cfg_t cur;

    // Format the addressed register for readback.
    always_comb begin
        cur = cfg_q[ch];
        case (cfg_sel_e'(sel))
            SEL_BASE: rdata = {cur.base, {(REG_W-CMP_W){1'b0}}};
            SEL_MASK: rdata = {cur.mask, {(REG_W-CMP_W-2){1'b0}}, cur.wp, cur.vld};
            SEL_CTRL: rdata = {{(REG_W-CTRL_W){1'b0}}, cur.ctrl};
            default:  rdata = '0;
        endcase
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/csdec_match.sv
// Module: address compare for one channel.
// Assumes the upper address half arrives alone; BOOT variant selects
// unconditionally while its own valid bit is clear.
module csdec_match
    import csdec_pkg::*;
#(
    parameter bit BOOT = 1'b0
) (
    input  ch_cfg_t          cfg,
    input  logic             bus_valid,
    input  logic [CMP_W-1:0] addr_hi,
    output logic             hit
);
    logic addr_eq;

    // Masked equality between address and base.
    always_comb begin
        addr_eq = (((addr_hi ^ cfg.base) & ~cfg.mask) == '0);
    end

    if (BOOT) begin : g_boot
        // Global select until validated, ordinary decode afterwards.
        always_comb hit = bus_valid && (!cfg.vld || addr_eq);
    end else begin : g_norm
        // Ordinary decode gated by the valid bit.
        always_comb hit = bus_valid && cfg.vld && addr_eq;
    end
endmodule

// File: rtl/csdec_arb.sv
// Module: lowest-index priority pick plus write-protect check.
// Assumes hit vector is already gated by access-valid.
module csdec_arb #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] wp,
    input  logic              bus_write,
    output logic [NUM_CH-1:0] cs_n,
    output logic              acc_err
);
    logic [NUM_CH-1:0] grant;
    logic              found;

    // Keep only the lowest-numbered hit.
    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    logic blocked;

    // Suppress the select and flag an error on a protected write.
    always_comb begin
        blocked = bus_write && ((grant & wp) != '0);
        acc_err = blocked;
        cs_n    = blocked ? '1 : ~grant;
    end
endmodule

// File: rtl/csdec_top.sv
// Module: eight-channel programmable chip-select decoder (top).
// Assumes the master presents address bits 31..16, a write flag and an
// access-valid strobe; decode is combinational, registers are clocked.
module csdec_top
    import csdec_pkg::*;
#(
    parameter int                NUM_CH    = 8,
    parameter int                CH_W      = 3,
    parameter logic [CTRL_W-1:0] CTRL_RST0 = 16'h3D80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [CMP_W-1:0]  bus_addr_hi,
    output logic [NUM_CH-1:0] cs_n,
    output logic              acc_err
);
    ch_cfg_t [NUM_CH-1:0] cfg;
    logic    [NUM_CH-1:0] hit;
    logic    [NUM_CH-1:0] vld_vec;
    logic    [NUM_CH-1:0] wp_vec;

    csdec_regs #(
        .NUM_CH    (NUM_CH),
        .CH_W      (CH_W),
        .CTRL_RST0 (CTRL_RST0),
        .CTRL_RSTN ('0)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .ch    (cfg_ch),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg_o (cfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_match
        csdec_match #(.BOOT(i == 0)) u_match (
            .cfg       (cfg[i]),
            .bus_valid (bus_valid),
            .addr_hi   (bus_addr_hi),
            .hit       (hit[i])
        );
        assign vld_vec[i] = cfg[i].vld;
        assign wp_vec[i]  = cfg[i].wp;
    end

    csdec_arb #(.NUM_CH(NUM_CH)) u_arb (
        .hit       (hit),
        .wp        (wp_vec),
        .bus_write (bus_write),
        .cs_n      (cs_n),
        .acc_err   (acc_err)
    );
endmodule

// File: rtl/csdec_chk.sv
// Module: protocol checker for csdec_top, attached by bind.
// Assumes it sees the top's ports and its valid/write-protect vectors.
module csdec_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [NUM_CH-1:0] cs_n,
    input logic              acc_err,
    input logic [NUM_CH-1:0] vld_vec,
    input logic [NUM_CH-1:0] wp_vec
);
    a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (&cs_n && !acc_err));

    a_r7_err_on_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> (bus_write && bus_valid && &cs_n));

    a_r2_boot_select: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !vld_vec[0] && !(bus_write && wp_vec[0])) |-> !cs_n[0]);

    for (genvar i = 1; i < NUM_CH; i++) begin : g_gate
        a_r5_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !cs_n[i] |-> (vld_vec[i] && vld_vec[0]));
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_wp
        a_r7_no_protected_write: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n[i] && bus_write) |-> !wp_vec[i]);
    end
endmodule

bind csdec_top csdec_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .cs_n      (cs_n),
    .acc_err   (acc_err),
    .vld_vec   (vld_vec),
    .wp_vec    (wp_vec)
);

// File: tb/tb_csdec_top.sv
// Bench: behavioural model compared every cycle plus directed checks.
module tb_csdec_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr_hi = '0;
    logic [7:0]  cs_n;
    logic        acc_err;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R9";
    bit done = 1'b0;

    int m_base [8];
    int m_mask [8];
    bit m_wp [8];
    bit m_v [8];
    int m_ctrl [8];

    csdec_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr_hi(bus_addr_hi),
        .cs_n(cs_n), .acc_err(acc_err)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_base[i] = 0; m_mask[i] = 0; m_wp[i] = 0; m_v[i] = 0;
            m_ctrl[i] = (i == 0) ? 32'h3D80 : 0;
        end
    endtask

    // Model register update on the clock edge that the DUT stores a write.
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else if (cfg_we) begin
            case (cfg_sel)
                2'd0: m_base[cfg_ch] = int'(cfg_wdata[31:16]);
                2'd1: begin
                    m_mask[cfg_ch] = int'(cfg_wdata[31:16]);
                    m_wp[cfg_ch] = cfg_wdata[1];
                    m_v[cfg_ch] = cfg_wdata[0];
                end
                2'd2: m_ctrl[cfg_ch] = int'(cfg_wdata[15:0]);
                default: ;
            endcase
        end
    end

    function automatic void model_decode(input bit val, input bit wr, input int ahi,
                                         output logic [7:0] e_cs, output logic e_err);
        int win = -1;
        e_cs = 8'hFF; e_err = 1'b0;
        if (val) begin
            if (!m_v[0]) win = 0;
            else begin
                for (int i = 0; i < 8; i++) begin
                    if (win < 0 && m_v[i] && (((ahi ^ m_base[i]) & ~m_mask[i] & 32'hFFFF) == 0))
                        win = i;
                end
            end
        end
        if (win >= 0) begin
            if (wr && m_wp[win]) e_err = 1'b1;
            else e_cs[win] = 1'b0;
        end
    endfunction

    function automatic int model_read(input int ch, input int sel);
        case (sel)
            0: return m_base[ch] << 16;
            1: return (m_mask[ch] << 16) | (int'(m_wp[ch]) << 1) | int'(m_v[ch]);
            2: return m_ctrl[ch];
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare decode outputs to the model every cycle, away from the edge.
    always @(negedge clk) begin
        logic [7:0] e_cs;
        logic e_err;
        #(CLK_P/4);
        if (rst_n && !done) begin
            model_decode(bus_valid, bus_write, int'(bus_addr_hi), e_cs, e_err);
            check({cur_tag, " cs_n"}, {24'h0, cs_n}, {24'h0, e_cs});
            check({cur_tag, " acc_err"}, {31'h0, acc_err}, {31'h0, e_err});
        end
    end

    task automatic cfg_write(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b0;
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int ch, input int sel, input logic [31:0] exp);
        @(negedge clk);
        cfg_we = 1'b0; cfg_ch = 3'(ch); cfg_sel = 2'(sel);
        #(CLK_P/4 + 1);
        check(tag, cfg_rdata, exp);
        check({tag, " model"}, cfg_rdata, model_read(ch, sel));
    endtask

    task automatic acc(input string tag, input bit val, input bit wr, input logic [15:0] ahi,
                       input logic [7:0] exp_cs, input bit exp_err);
        @(negedge clk);
        cur_tag = tag;
        bus_valid = val; bus_write = wr; bus_addr_hi = ahi;
        #(CLK_P/4 + 1);
        check({tag, " directed cs_n"}, {24'h0, cs_n}, {24'h0, exp_cs});
        check({tag, " directed acc_err"}, {31'h0, acc_err}, {31'h0, exp_err});
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values through readback
        for (int c = 0; c < 8; c++) begin
            rd_check("R1 base", c, 0, 32'h0);
            rd_check("R1 mask", c, 1, 32'h0);
            rd_check("R1 ctrl", c, 2, (c == 0) ? 32'h3D80 : 32'h0);
        end
        rd_check("R1 sel3", 0, 3, 32'h0);

        // R9: no access, no select
        acc("R9", 1'b0, 1'b1, 16'h0000, 8'hFF, 1'b0);

        // R2: boot behaviour of channel 0
        acc("R2", 1'b1, 1'b0, 16'h1234, 8'hFE, 1'b0);
        acc("R2", 1'b1, 1'b1, 16'hFFFF, 8'hFE, 1'b0);
        cfg_write(1, 0, 32'h0000_0000);
        cfg_write(1, 1, 32'h0000_0001);
        acc("R2", 1'b1, 1'b0, 16'h0000, 8'hFE, 1'b0);

        // R4: contiguous 32 MB and 16 MB regions
        cfg_write(1, 0, 32'h0200_0000);
        cfg_write(1, 1, 32'h00FF_0001);
        cfg_write(0, 0, 32'h0000_0000);
        cfg_write(0, 1, 32'h01FF_0001);
        acc("R4", 1'b1, 1'b0, 16'h0000, 8'hFE, 1'b0);
        acc("R4", 1'b1, 1'b1, 16'h01FF, 8'hFE, 1'b0);
        acc("R4", 1'b1, 1'b0, 16'h0200, 8'hFD, 1'b0);
        acc("R4", 1'b1, 1'b0, 16'h02FF, 8'hFD, 1'b0);
        acc("R8", 1'b1, 1'b1, 16'h0300, 8'hFF, 1'b0);

        // R10: readback layout
        rd_check("R10 mask", 1, 1, 32'h00FF_0001);
        rd_check("R10 base", 1, 0, 32'h0200_0000);
        cfg_write(0, 2, 32'hABCD_1234);
        rd_check("R10 ctrl", 0, 2, 32'h0000_1234);

        // R3: masked compare with non-contiguous don't-care bits
        cfg_write(2, 0, 32'h8000_FFFF);
        cfg_write(2, 1, 32'h0011_0001);
        rd_check("R10 base low bits", 2, 0, 32'h8000_0000);
        acc("R3", 1'b1, 1'b0, 16'h8000, 8'hFB, 1'b0);
        acc("R3", 1'b1, 1'b0, 16'h8001, 8'hFB, 1'b0);
        acc("R3", 1'b1, 1'b0, 16'h8010, 8'hFB, 1'b0);
        acc("R3", 1'b1, 1'b1, 16'h8011, 8'hFB, 1'b0);
        acc("R3", 1'b1, 1'b0, 16'h8002, 8'hFF, 1'b0);
        acc("R3", 1'b1, 1'b0, 16'h8100, 8'hFF, 1'b0);

        // R5: valid gating
        cfg_write(3, 0, 32'h9000_0000);
        cfg_write(3, 1, 32'h0000_0000);
        acc("R5", 1'b1, 1'b0, 16'h9000, 8'hFF, 1'b0);
        cfg_write(3, 1, 32'h0000_0001);
        acc("R5", 1'b1, 1'b0, 16'h9000, 8'hF7, 1'b0);

        // R6: lowest index wins among overlapping channels
        cfg_write(4, 0, 32'h9000_0000);
        cfg_write(4, 1, 32'h0000_0001);
        cfg_write(5, 0, 32'h9000_0000);
        cfg_write(5, 1, 32'h00FF_0001);
        acc("R6", 1'b1, 1'b0, 16'h9000, 8'hF7, 1'b0);
        acc("R6", 1'b1, 1'b0, 16'h9001, 8'hDF, 1'b0);

        // R7: write protection
        cfg_write(3, 1, 32'h0000_0003);
        acc("R7", 1'b1, 1'b1, 16'h9000, 8'hFF, 1'b1);
        acc("R7", 1'b1, 1'b0, 16'h9000, 8'hF7, 1'b0);
        acc("R7", 1'b1, 1'b1, 16'h9001, 8'hDF, 1'b0);

        // R10: mask change takes effect on the next access
        cfg_write(3, 1, 32'h0000_0000);
        acc("R10", 1'b1, 1'b0, 16'h9000, 8'hEF, 1'b0);
        acc("R9", 1'b0, 1'b0, 16'h9000, 8'hFF, 1'b0);

        // R11: random traffic with occasional reconfiguration
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            cur_tag = "R11";
            if (($urandom % 16) == 0) begin
                cfg_we = 1'b1;
                cfg_ch = 3'($urandom % 8);
                cfg_sel = 2'($urandom % 2);
                cfg_wdata = {4'h0, 4'($urandom % 3), 8'($urandom % 4), 14'h0, 2'($urandom % 4)};
                bus_valid = 1'b0;
            end else begin
                cfg_we = 1'b0;
                bus_valid = ($urandom % 8) != 0;
                bus_write = $urandom % 2;
                bus_addr_hi = {4'($urandom % 3), 4'h0, 8'($urandom % 4)};
            end
        end
        @(negedge clk);
        cfg_we = 1'b0; bus_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule